// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is a bank of general-purpose pins reached over a minimal register bus made of a write strobe, a read strobe, an address and a data word. It holds an output latch and, when the build asks for one, a direction register. It drives one output value and one output enable per pad, and it returns the pin levels through a two-flop synchronizer. The register width is also the pin count.

Build parameters choose three things. The first is how software changes the outputs: a single data word, separate set and clear words, or one full-value output word. The second is whether there is a direction register, and what a 1 means in it. The third is whether pin n sits at bit n or at the mirrored bit. Software sees one fixed address map, and each write style decodes only the words it defines.

Top module: `gpio_port`

## Requirements
- R1: The address map is word 0 = pin levels, word 1 = set word (or the full output word), word 2 = clear word, word 3 = direction. Any address above 3 is outside the map: writes there change nothing and reads there return zero.
- R2: A write changes state only at the rising clock edge that samples `bus_we` high, and it is not visible on the pads before that edge. With `bus_we` low, no register changes.
- R3: With WRITE_MODE=0 (plain), a write to word 0 loads the whole output latch. Writes to words 1 and 2 are ignored.
- R4: With WRITE_MODE=1 (set/clear), each 1 bit written to word 1 drives that output high and each 1 bit written to word 2 drives it low. Zero bits leave outputs as they were. Writes to word 0 are ignored.
- R5: With WRITE_MODE=2 (set-only), a write to word 1 loads the whole output latch. Writes to words 0 and 2 are ignored.
- R6: With DIR_MODE=1, a direction bit of 1 makes the pin an output. With DIR_MODE=2, a direction bit of 1 makes the pin an input. Word 3 is written whole and reads back the stored value.
- R7: With DIR_MODE=0 there is no direction register: every pad output enable is asserted at all times, writes to word 3 have no effect and word 3 reads zero.
- R8: Reset clears the output latch and the read data. It sets the direction register so that every pin is an input: all zeros for DIR_MODE=1, all ones for DIR_MODE=2.
- R9: `pad_oe` is high exactly for pins configured as outputs. `pad_out` carries the latch bit for those pins and 0 for the others.
- R10: `bus_rdata` is loaded at the rising edge that samples `bus_re` high and holds its value at other times. Words 1 and 2 always read zero.
- R11: A pin level held steady appears in a read of word 0 captured at the third rising edge after it settles. Reads captured at the first two edges return the previous level.
- R12: With REVERSE=1, pin n maps to bit WIDTH-1-n in every register, read data included. With REVERSE=0, pin n maps to bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_re | input | 1 | Read strobe, data valid the next cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pad_in | input | WIDTH | Asynchronous pin levels |
| pad_out | output | WIDTH | Output value per pad |
| pad_oe | output | WIDTH | Output enable per pad, 1 drives the pad |

## Verification
The properties assume that the strobes and the address are known values once reset is released. They also assume that a write and a read may share a cycle without ordering rules between them. The pin inputs are treated as free-running, so no property predicts a read of word 0. The bench keeps its pin changes on falling edges. It holds each level for at least two rising edges before it expects that level in a read, except in the latency check, which samples the two older reads on purpose. Three builds (mirrored set/clear with input-polarity direction, plain with output-polarity direction, and set-only with no direction) share one bus, so every write exercises every decode path at once.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    // output write styles
    localparam int WR_PLAIN   = 0;
    localparam int WR_SETCLR  = 1;
    localparam int WR_SETONLY = 2;
    // direction register styles
    localparam int DIR_NONE   = 0;
    localparam int DIR_OUT_HI = 1;
    localparam int DIR_IN_HI  = 2;

    typedef enum logic [1:0] {
        SLOT_PINS = 2'd0,
        SLOT_SET  = 2'd1,
        SLOT_CLR  = 2'd2,
        SLOT_DIR  = 2'd3
    } slot_e;
endpackage

// File: rtl/gpio_bitmap.sv
// Maps between register bit order and pin order; the mapping is its own inverse.
module gpio_bitmap #(
    parameter int WIDTH   = 32,
    parameter int REVERSE = 0
) (
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst
);
    if (REVERSE != 0) begin : g_mirror
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign dst[i] = src[WIDTH-1-i];
        end
    end else begin : g_straight
        assign dst = src;
    end
endmodule

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for asynchronous pin levels.
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta   = async_in;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_out = sync_q.stable;
endmodule

// File: rtl/gpio_pad_ctrl.sv
// Output enable from the direction style, pad value gated by the enable.
module gpio_pad_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int DIR_MODE = DIR_OUT_HI
) (
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] out
);
    if (DIR_MODE == DIR_OUT_HI) begin : g_out_hi
        assign oe = dir;
    end else if (DIR_MODE == DIR_IN_HI) begin : g_in_hi
        assign oe = ~dir;
    end else begin : g_none
        logic [WIDTH-1:0] unused_dir;
        assign unused_dir = dir;
        assign oe = {WIDTH{1'b1}};
    end

    assign out = latch & oe;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int WRITE_MODE = WR_SETCLR,
    parameter int DIR_MODE   = DIR_OUT_HI,
    parameter int REVERSE    = 0,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    localparam bit               HAS_DIR = (DIR_MODE != DIR_NONE);
    localparam logic [WIDTH-1:0] DIR_RST = (DIR_MODE == DIR_IN_HI) ?
                                           {WIDTH{1'b1}} : {WIDTH{1'b0}};

    typedef struct packed {
        logic [WIDTH-1:0] latch;   // pin order
        logic [WIDTH-1:0] dir;     // pin order
        logic [WIDTH-1:0] rdata;   // register order
    } port_state_t;

    port_state_t      state_d, state_q;
    logic [WIDTH-1:0] wr_pins;
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] rd_sel;
    logic [WIDTH-1:0] rd_word;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic             in_map;
    slot_e            slot;

    assign in_map  = ((bus_addr >> 2) == '0);
    assign slot    = slot_e'(bus_addr[1:0]);
    assign latch_q = state_q.latch;
    assign dir_q   = state_q.dir;

    gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_wmap (
        .src (bus_wdata),
        .dst (wr_pins)
    );

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    // read source selection in pin order
    always_comb begin
        rd_sel = '0;
        if (in_map) begin
            case (slot)
                SLOT_PINS: rd_sel = pins_sync;
                SLOT_DIR:  rd_sel = HAS_DIR ? state_q.dir : '0;
                default:   rd_sel = '0;
            endcase
        end
    end

    gpio_bitmap #(.WIDTH(WIDTH), .REVERSE(REVERSE)) u_rmap (
        .src (rd_sel),
        .dst (rd_word)
    );

    always_comb begin
        state_d = state_q;
        if (bus_we && in_map) begin
            case (slot)
                SLOT_PINS: begin
                    if (WRITE_MODE == WR_PLAIN) state_d.latch = wr_pins;
                end
                SLOT_SET: begin
                    if (WRITE_MODE == WR_SETCLR)
                        state_d.latch = state_q.latch | wr_pins;
                    else if (WRITE_MODE == WR_SETONLY)
                        state_d.latch = wr_pins;
                end
                SLOT_CLR: begin
                    if (WRITE_MODE == WR_SETCLR)
                        state_d.latch = state_q.latch & ~wr_pins;
                end
                SLOT_DIR: begin
                    if (HAS_DIR) state_d.dir = wr_pins;
                end
                default: ;
            endcase
        end
        if (bus_re) state_d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.latch <= '0;
            state_q.dir   <= DIR_RST;
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    gpio_pad_ctrl #(.WIDTH(WIDTH), .DIR_MODE(DIR_MODE)) u_pad (
        .latch (state_q.latch),
        .dir   (state_q.dir),
        .oe    (pad_oe),
        .out   (pad_out)
    );

    assign bus_rdata = state_q.rdata;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int WRITE_MODE = WR_SETCLR,
    parameter int DIR_MODE   = DIR_OUT_HI,
    parameter int ADDR_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  wr_pins,
    input logic [WIDTH-1:0]  latch_q,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  bus_rdata
);
    logic in_map;
    assign in_map = ((bus_addr >> 2) == '0);

    // R2: no register moves without a write strobe
    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(latch_q) && $stable(dir_q)));

    // R4: set word raises its ones and keeps the rest
    a_r4_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_MODE == WR_SETCLR && bus_we && in_map && bus_addr[1:0] == 2'd1)
        |=> (((latch_q & $past(wr_pins)) == $past(wr_pins)) &&
             ((latch_q & ~$past(wr_pins)) == ($past(latch_q) & ~$past(wr_pins)))));

    // R4: clear word lowers its ones and keeps the rest
    a_r4_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_MODE == WR_SETCLR && bus_we && in_map && bus_addr[1:0] == 2'd2)
        |=> (((latch_q & $past(wr_pins)) == '0) &&
             ((latch_q & ~$past(wr_pins)) == ($past(latch_q) & ~$past(wr_pins)))));

    // R6: direction word is loaded whole
    a_r6_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR_MODE != DIR_NONE && bus_we && in_map && bus_addr[1:0] == 2'd3)
        |=> (dir_q == $past(wr_pins)));

    // R10 and R1: write-only words and unmapped addresses read zero
    a_r10_hidden_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (!in_map || bus_addr[1:0] == 2'd1 || bus_addr[1:0] == 2'd2))
        |=> (bus_rdata == '0));

    // R10: read data holds between read strobes
    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH      (WIDTH),
    .WRITE_MODE (WRITE_MODE),
    .DIR_MODE   (DIR_MODE),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .wr_pins   (wr_pins),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .bus_rdata (bus_rdata)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    import gpio_port_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int AW = 3;
    localparam int NDUT = 3;
    localparam int WM [NDUT] = '{WR_SETCLR, WR_PLAIN, WR_SETONLY};
    localparam int DM [NDUT] = '{DIR_IN_HI, DIR_OUT_HI, DIR_NONE};
    localparam int RV [NDUT] = '{1, 0, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  pins = '0;
    logic [W-1:0]  rdata [NDUT];
    logic [W-1:0]  pout  [NDUT];
    logic [W-1:0]  poe   [NDUT];

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    typedef struct {
        int         idx;
        logic [W-1:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sbq [$];

    logic [W-1:0] m_lat [NDUT];
    logic [W-1:0] m_dir [NDUT];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port #(.WIDTH(W), .WRITE_MODE(WM[0]), .DIR_MODE(DM[0]), .REVERSE(RV[0]), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .pad_in(pins), .pad_out(pout[0]), .pad_oe(poe[0]));
    gpio_port #(.WIDTH(W), .WRITE_MODE(WM[1]), .DIR_MODE(DM[1]), .REVERSE(RV[1]), .ADDR_W(AW)) u_dut_plain (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .pad_in(pins), .pad_out(pout[1]), .pad_oe(poe[1]));
    gpio_port #(.WIDTH(W), .WRITE_MODE(WM[2]), .DIR_MODE(DM[2]), .REVERSE(RV[2]), .ADDR_W(AW)) u_dut_setonly (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata[2]), .pad_in(pins), .pad_out(pout[2]), .pad_oe(poe[2]));

    function automatic logic [W-1:0] to_order(logic [W-1:0] x, int i);
        logic [W-1:0] r;
        if (RV[i] == 0) return x;
        for (int b = 0; b < W; b++) r[b] = x[W-1-b];
        return r;
    endfunction

    function automatic logic [W-1:0] exp_oe(int i);
        if (DM[i] == DIR_OUT_HI) return m_dir[i];
        if (DM[i] == DIR_IN_HI)  return ~m_dir[i];
        return '1;
    endfunction

    function automatic logic [W-1:0] exp_read(int i, int a, logic [W-1:0] pv);
        if (a == 0) return to_order(pv, i);
        if (a == 3 && DM[i] != DIR_NONE) return to_order(m_dir[i], i);
        return '0;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NDUT; i++) begin
            m_lat[i] = '0;
            m_dir[i] = (DM[i] == DIR_IN_HI) ? '1 : '0;
        end
    endtask

    task automatic model_write(int a, logic [W-1:0] d);
        for (int i = 0; i < NDUT; i++) begin
            logic [W-1:0] m;
            m = to_order(d, i);
            case (a)
                0: if (WM[i] == WR_PLAIN) m_lat[i] = m;
                1: if (WM[i] == WR_SETCLR) m_lat[i] = m_lat[i] | m;
                   else if (WM[i] == WR_SETONLY) m_lat[i] = m;
                2: if (WM[i] == WR_SETCLR) m_lat[i] = m_lat[i] & ~m;
                3: if (DM[i] != DIR_NONE) m_dir[i] = m;
                default: ;
            endcase
        end
    endtask

    task automatic check_pads(string tag);
        for (int i = 0; i < NDUT; i++) begin
            check({tag, $sformatf(" oe[%0d]", i)}, poe[i], exp_oe(i));
            check({tag, $sformatf(" out[%0d]", i)}, pout[i], m_lat[i] & exp_oe(i));
        end
    endtask

    // driver: starts and ends on a falling edge
    task automatic do_write(int a, logic [W-1:0] d, string tag);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        #1 check_pads("R2 not visible before edge");
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
        check_pads(tag);
    endtask

    task automatic do_read(int a, logic [W-1:0] pv, string tag);
        bus_re = 1'b1; bus_addr = AW'(a);
        for (int i = 0; i < NDUT; i++) begin
            sb_item_t it;
            it.idx = i; it.exp = exp_read(i, a, pv); it.tag = tag;
            sbq.push_back(it);
        end
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    // monitor: a read strobed at a rising edge is compared at the next falling edge
    initial begin
        forever begin
            bit pend;
            @(posedge clk);
            pend = bus_re && rst_n;
            @(negedge clk);
            if (pend) begin
                for (int k = 0; k < NDUT; k++) begin
                    if (sbq.size() == 0) begin
                        check("R10 scoreboard underflow", '1, '0);
                    end else begin
                        sb_item_t it;
                        it = sbq.pop_front();
                        check({it.tag, $sformatf(" rd[%0d]", it.idx)}, rdata[it.idx], it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_pads("R8 R7 pads during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_pads("R8 R7 pads after reset");
        for (int i = 0; i < NDUT; i++) check("R8 read data after reset", rdata[i], '0);
        do_read(3, pins, "R8 R7 direction reset value");

        // pin read path and bit order
        pins = 8'h0B;
        repeat (3) @(negedge clk);
        do_read(0, 8'h0B, "R12 R1 pin read");

        // synchronizer latency
        pins = 8'h5C;
        do_read(0, 8'h0B, "R11 first edge old level");
        do_read(0, 8'h0B, "R11 second edge old level");
        do_read(0, 8'h5C, "R11 third edge new level");

        // direction
        do_write(3, 8'h0F, "R6 R7 R12 direction write");
        do_read(3, pins, "R6 R7 direction readback");

        // output write styles
        do_write(0, 8'hA5, "R3 plain load, R4 R5 ignore word 0");
        do_write(1, 8'h31, "R4 set, R5 full load, R3 ignores word 1");
        do_write(2, 8'h21, "R4 clear, R3 R5 ignore word 2");
        do_write(1, 8'h02, "R4 zero bits hold R12");

        // no strobe, no change
        bus_addr = 3'd0; bus_wdata = 8'hFF;
        repeat (3) @(negedge clk);
        check_pads("R2 no write strobe");

        // pad gating follows direction
        do_write(3, 8'hFF, "R9 R6 all-ones direction");
        do_write(3, 8'h00, "R9 R6 all-zeros direction");

        // write-only words and read hold
        do_read(1, pins, "R10 set word reads zero");
        do_read(2, pins, "R10 clear word reads zero");
        do_read(0, 8'h5C, "R10 R12 pin read");
        bus_addr = 3'd3;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NDUT; i++) check("R10 read data holds", rdata[i], to_order(8'h5C, i));

        // outside the map
        do_write(4, 8'hFF, "R1 unmapped write ignored");
        do_read(4, pins, "R1 unmapped read zero");
        do_read(3, pins, "R1 direction untouched by unmapped write");

        // reset during operation
        rst_n = 1'b0;
        #1 model_reset();
        check_pads("R8 reset mid-run");
        for (int i = 0; i < NDUT; i++) check("R8 read data cleared", rdata[i], '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(3, pins, "R8 direction after second reset");
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule